// File: doc/BRIEF.md
# Two-Priority Process Dispatcher

This block decides which process a processor core runs next. Each process is named by a workspace pointer. Pointers are word-aligned, so the dispatcher uses bit 0 as the priority: 0 is urgent and 1 is background. Ready processes wait in one of two small FIFOs. The core reports two kinds of event for the process that is running:

- `proc_done`: the process finished or blocked.
- `sched_point`: the process reached a point where it may be descheduled.

A periodic single-cycle `tick` strobe measures background time slices. The dispatcher presents the chosen process on `cur_wptr`, qualified by `cur_valid`.

Urgent work runs until it reports `proc_done`, and other urgent entries are taken in arrival order. Background work runs only when no urgent process runs or waits. A background process whose slice has expired gives way at its next scheduling point, and its pointer goes to the tail of the background FIFO, which gives round-robin rotation.

An urgent arrival displaces a running background process on the next clock edge. For one cycle `save_regs` signals that the displaced process's state must be stored. The displaced process is parked inside the block and resumes first once urgent work drains.

An entry presented in a cycle when the dispatcher can start it goes straight to `cur_wptr` without passing through a FIFO, so dispatch takes one cycle from request.

Top module: `proc_sched`

## Requirements
- R1: After reset, `cur_valid`, `save_regs`, `hi_full`, `lo_full`, `hi_overflow` and `lo_overflow` are all 0.
- R2: Bit 0 of `enq_wptr` selects the list: 0 is urgent and 1 is background. An entry enqueued while nothing runs appears on `cur_wptr` with `cur_valid`=1 after the next clock edge.
- R3: A running urgent process stays on `cur_wptr` until `proc_done`, and `tick` and `sched_point` do not affect it. Queued urgent entries are then dispatched in arrival order.
- R4: A background process is dispatched only when no urgent process is running and the urgent list is empty.
- R5: A background slice expires once `SLICE_TICKS` tick strobes (default 2) have been seen while that process runs. The count restarts at every background dispatch, and a `sched_point` before expiry is ignored.
- R6: At a `sched_point` after expiry, the process is appended to the background tail and the head is dispatched. If a new background entry arrives in the same cycle, the rotated process is queued ahead of it.
- R7: An urgent entry arriving while a background process runs takes `cur_wptr` on the next edge. In that same cycle `save_regs` is 1, and it lasts exactly one cycle.
- R8: When urgent work drains, the displaced background process resumes before any queued background entry.
- R9: `proc_done` removes the running process without requeueing it. With nothing ready, `cur_valid` drops to 0. `proc_done` and `sched_point` have no effect while `cur_valid` is 0.
- R10: A list holding `DEPTH` entries (default 4) raises its full flag. An enqueue into a full list is refused and sets that list's overflow flag, which stays set until reset. A refused entry is never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Ready-process request |
| enq_wptr | input | PTR_W | Workspace pointer; bit 0 is the priority (1 = background) |
| proc_done | input | 1 | Running process completed or blocked |
| sched_point | input | 1 | Running process is at a descheduling point |
| tick | input | 1 | Single-cycle time-slice strobe |
| cur_valid | output | 1 | A process is running |
| cur_wptr | output | PTR_W | Pointer of the running process |
| save_regs | output | 1 | Displaced background process needs its state saved |
| hi_full | output | 1 | Urgent list full |
| lo_full | output | 1 | Background list full |
| hi_overflow | output | 1 | Sticky: urgent enqueue refused |
| lo_overflow | output | 1 | Sticky: background enqueue refused |

## Verification
Some properties are checked on every cycle:

- A running urgent process is never displaced without `proc_done`.
- A background process never runs while urgent entries wait.
- An urgent arrival takes over within one cycle and raises `save_regs`.
- A scheduling point before slice expiry changes nothing.
- Neither list is popped while empty or filled past its depth.

Other behaviours only the bench's scenarios can show, because they depend on order over many cycles:

- Round-robin rotation across three background processes.
- The parked process returning ahead of the queue.
- Rotated-before-new ordering on a shared cycle.
- A refused entry never surfacing.

// File: rtl/sched_pkg.sv
package sched_pkg;

    // Where the next running process comes from
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_HI_Q,
        SRC_HI_IN,
        SRC_PARK,
        SRC_LO_Q,
        SRC_ROT,
        SRC_LO_IN
    } pick_e;

    function automatic logic is_lo_src(input pick_e s);
        return (s == SRC_PARK) || (s == SRC_LO_Q) || (s == SRC_ROT) || (s == SRC_LO_IN);
    endfunction

endpackage

// File: rtl/ready_fifo.sv
module ready_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push0,
    input  logic [W-1:0] din0,
    input  logic         push1,
    input  logic [W-1:0] din1,
    input  logic         pop,
    output logic         empty,
    output logic         full,
    output logic [W-1:0] head,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [CW-1:0] space;
    logic          acc0, acc1, pop_ok;
    logic [AW-1:0] wp;

    always_comb begin
        st_d   = st_q;
        space  = CW'(DEPTH) - st_q.cnt;
        acc0   = push0 && (space != '0);
        acc1   = push1 && (space > CW'(acc0));
        pop_ok = pop && (st_q.cnt != '0);
        wp     = st_q.wr;
        if (acc0) begin
            st_d.mem[wp] = din0;
            wp           = wrap_inc(wp);
        end
        if (acc1) begin
            st_d.mem[wp] = din1;
            wp           = wrap_inc(wp);
        end
        st_d.wr = wp;
        if (pop_ok) begin
            st_d.rd = wrap_inc(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(acc0) + CW'(acc1) - CW'(pop_ok);
        st_d.ovf = st_q.ovf | (push0 & ~acc0) | (push1 & ~acc1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign head  = st_q.mem[st_q.rd];
    assign ovf   = st_q.ovf;

    // R10
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

// File: rtl/slice_timer.sv
module slice_timer #(
    parameter int SLICE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_en,
    output logic expired
);
    localparam int CW = $clog2(SLICE_TICKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick_en && (cnt_q != CW'(SLICE_TICKS))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CW'(SLICE_TICKS));

    // R5
    slice_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !expired);

    // R5
    slice_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SLICE_TICKS));

endmodule

// File: rtl/proc_sched.sv
module proc_sched #(
    parameter int PTR_W       = 16,
    parameter int DEPTH       = 4,
    parameter int SLICE_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [PTR_W-1:0] enq_wptr,
    input  logic             proc_done,
    input  logic             sched_point,
    input  logic             tick,
    output logic             cur_valid,
    output logic [PTR_W-1:0] cur_wptr,
    output logic             save_regs,
    output logic             hi_full,
    output logic             lo_full,
    output logic             hi_overflow,
    output logic             lo_overflow
);
    import sched_pkg::*;

    typedef struct packed {
        logic             run_v;
        logic [PTR_W-1:0] run_p;
        logic             park_v;
        logic [PTR_W-1:0] park_p;
        logic             save;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic             hi_empty, lo_empty;
    logic [PTR_W-1:0] hi_head, lo_head;
    logic             hi_push, hi_pop, lo_push0, lo_push1, lo_pop;
    logic             slice_clr, slice_tick, slice_expired;
    logic             run_lo, in_hi, in_lo, leave, rotate, free, hi_avail, preempt;
    pick_e            src;

    ready_fifo #(.DEPTH(DEPTH), .W(PTR_W)) u_hi_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push0 (hi_push),
        .din0  (enq_wptr),
        .push1 (1'b0),
        .din1  ('0),
        .pop   (hi_pop),
        .empty (hi_empty),
        .full  (hi_full),
        .head  (hi_head),
        .ovf   (hi_overflow)
    );

    ready_fifo #(.DEPTH(DEPTH), .W(PTR_W)) u_lo_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push0 (lo_push0),
        .din0  (st_q.run_p),
        .push1 (lo_push1),
        .din1  (enq_wptr),
        .pop   (lo_pop),
        .empty (lo_empty),
        .full  (lo_full),
        .head  (lo_head),
        .ovf   (lo_overflow)
    );

    slice_timer #(.SLICE_TICKS(SLICE_TICKS)) u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (slice_clr),
        .tick_en (slice_tick),
        .expired (slice_expired)
    );

    always_comb begin
        st_d      = st_q;
        st_d.save = 1'b0;

        run_lo   = st_q.run_v & st_q.run_p[0];
        in_hi    = enq_valid & ~enq_wptr[0];
        in_lo    = enq_valid & enq_wptr[0];
        leave    = st_q.run_v & proc_done;
        rotate   = run_lo & sched_point & slice_expired & ~proc_done;
        free     = ~st_q.run_v | leave | rotate;
        hi_avail = ~hi_empty | in_hi;
        preempt  = run_lo & ~free & hi_avail;

        // Choose the source of the next running process
        src = SRC_NONE;
        if ((free | preempt) & hi_avail) begin
            src = hi_empty ? SRC_HI_IN : SRC_HI_Q;
        end else if (free) begin
            if (st_q.park_v)  src = SRC_PARK;
            else if (!lo_empty) src = SRC_LO_Q;
            else if (rotate)  src = SRC_ROT;
            else if (in_lo)   src = SRC_LO_IN;
        end

        // Entries not taken straight through go to their lists
        hi_push  = in_hi & (src != SRC_HI_IN);
        lo_push0 = rotate & (src != SRC_ROT);
        lo_push1 = in_lo & (src != SRC_LO_IN);
        hi_pop   = (src == SRC_HI_Q);
        lo_pop   = (src == SRC_LO_Q);

        unique case (src)
            SRC_HI_Q:  begin st_d.run_v = 1'b1; st_d.run_p = hi_head;     end
            SRC_HI_IN: begin st_d.run_v = 1'b1; st_d.run_p = enq_wptr;    end
            SRC_PARK:  begin st_d.run_v = 1'b1; st_d.run_p = st_q.park_p; end
            SRC_LO_Q:  begin st_d.run_v = 1'b1; st_d.run_p = lo_head;     end
            SRC_ROT:   begin st_d.run_v = 1'b1; st_d.run_p = st_q.run_p;  end
            SRC_LO_IN: begin st_d.run_v = 1'b1; st_d.run_p = enq_wptr;    end
            default:   begin if (free) st_d.run_v = 1'b0;                 end
        endcase

        if (preempt) begin
            st_d.park_v = 1'b1;
            st_d.park_p = st_q.run_p;
            st_d.save   = 1'b1;
        end
        if (src == SRC_PARK) begin
            st_d.park_v = 1'b0;
        end

        slice_clr  = is_lo_src(src);
        slice_tick = run_lo & tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_valid = st_q.run_v;
    assign cur_wptr  = st_q.run_p;
    assign save_regs = st_q.save;

    // R3
    hi_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && !cur_wptr[0] && !proc_done) |=> (cur_valid && cur_wptr == $past(cur_wptr)));

    // R4
    lo_runs_hi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && cur_wptr[0]) |-> hi_empty);

    // R5
    no_early_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && cur_wptr[0] && sched_point && !slice_expired && !proc_done && !enq_valid)
        |=> (cur_valid && cur_wptr == $past(cur_wptr)));

    // R7
    preempt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && cur_wptr[0] && !proc_done && !sched_point && enq_valid && !enq_wptr[0])
        |=> (cur_valid && cur_wptr == $past(enq_wptr) && save_regs));

    // R7
    save_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_regs |=> !save_regs);

    // R8
    save_implies_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_regs |-> (st_q.park_v && cur_valid && !cur_wptr[0]));

endmodule

// File: tb/tb_proc_sched.sv
`timescale 1ns/1ps
module tb_proc_sched;
    localparam int PTR_W = 16;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enq_valid = 1'b0;
    logic [PTR_W-1:0] enq_wptr = '0;
    logic             proc_done = 1'b0;
    logic             sched_point = 1'b0;
    logic             tick = 1'b0;
    logic             cur_valid;
    logic [PTR_W-1:0] cur_wptr;
    logic             save_regs, hi_full, lo_full, hi_overflow, lo_overflow;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    proc_sched #(.PTR_W(PTR_W), .DEPTH(DEPTH), .SLICE_TICKS(2)) dut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_wptr(enq_wptr),
        .proc_done(proc_done), .sched_point(sched_point), .tick(tick),
        .cur_valid(cur_valid), .cur_wptr(cur_wptr), .save_regs(save_regs),
        .hi_full(hi_full), .lo_full(lo_full),
        .hi_overflow(hi_overflow), .lo_overflow(lo_overflow)
    );

    typedef struct packed {
        logic        ev;
        logic [15:0] ep;
        logic        dn;
        logic        ds;
        logic        tk;
        logic        xv;
        logic [15:0] xp;
        logic        xs;
        logic [4:0]  rq;
    } vec_t;

    localparam int NV = 25;
    // Fields: enq_valid, enq_wptr, done, sched_point, tick | exp valid, exp ptr, exp save, requirement
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 16'h0201, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0201, 1'b0, 5'd2},  // R2 idle dispatch of background
        '{1'b1, 16'h0205, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0201, 1'b0, 5'd4},  // R4 queued behind running
        '{1'b1, 16'h0209, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0201, 1'b0, 5'd4},
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0201, 1'b0, 5'd5},  // R5 first tick
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0201, 1'b0, 5'd5},  // R5 early sched point ignored
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0201, 1'b0, 5'd5},  // R5 second tick expires
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0205, 1'b0, 5'd6},  // R6 rotate
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0205, 1'b0, 5'd5},
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0205, 1'b0, 5'd5},
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0209, 1'b0, 5'd6},  // R6 rotate again
        '{1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0100, 1'b1, 5'd7},  // R7 preemption
        '{1'b1, 16'h0104, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0100, 1'b0, 5'd7},  // R7 save lasts one cycle
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0100, 1'b0, 5'd3},  // R3 urgent ignores tick/point
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0104, 1'b0, 5'd3},  // R3 next urgent in order
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0209, 1'b0, 5'd8},  // R8 parked resumes first
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0201, 1'b0, 5'd9},  // R9 done removes
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0205, 1'b0, 5'd6},  // R6 round robin continues
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0205, 1'b0, 5'd5},
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0205, 1'b0, 5'd5},
        '{1'b1, 16'h020D, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0205, 1'b0, 5'd6},  // R6 rotated ahead of new
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h020D, 1'b0, 5'd6},
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 5'd9},  // R9 goes idle
        '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 5'd9},  // R9 events while idle ignored
        '{1'b1, 16'h0108, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0108, 1'b0, 5'd2},  // R2 idle dispatch of urgent
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 5'd9}
    };

    task automatic check(input logic ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic ev, input logic [15:0] ep, input logic dn,
                         input logic ds, input logic tk);
        enq_valid   = ev;
        enq_wptr    = ep;
        proc_done   = dn;
        sched_point = ds;
        tick        = tk;
    endtask

    task automatic expect_cur(input int req, input logic xv, input logic [15:0] xp);
        check(cur_valid == xv && (!xv || cur_wptr == xp), req, "cur",
              {15'd0, cur_valid, cur_wptr}, {15'd0, xv, xp});
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cur_valid == 1'b0, 1, "cur_valid", {31'd0, cur_valid}, 32'd0);
        check(save_regs == 1'b0, 1, "save_regs", {31'd0, save_regs}, 32'd0);
        check({hi_full, lo_full, hi_overflow, lo_overflow} == 4'b0, 1, "flags",
              {28'd0, hi_full, lo_full, hi_overflow, lo_overflow}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ev, VEC[i].ep, VEC[i].dn, VEC[i].ds, VEC[i].tk);
            @(negedge clk);
            check(cur_valid == VEC[i].xv && (!VEC[i].xv || cur_wptr == VEC[i].xp)
                  && save_regs == VEC[i].xs, int'(VEC[i].rq), $sformatf("vector %0d", i),
                  {14'd0, save_regs, cur_valid, cur_wptr},
                  {14'd0, VEC[i].xs, VEC[i].xv, VEC[i].xp});
        end
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);

        // R10 urgent list fill and overflow
        drive(1'b1, 16'h0100, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        expect_cur(10, 1'b1, 16'h0100);
        for (int k = 1; k <= DEPTH; k++) begin
            drive(1'b1, 16'(16'h0100 + 4 * k), 1'b0, 1'b0, 1'b0);
            @(negedge clk);
        end
        check(hi_full == 1'b1, 10, "hi_full", {31'd0, hi_full}, 32'd1);
        check(hi_overflow == 1'b0, 10, "hi_overflow before", {31'd0, hi_overflow}, 32'd0);
        drive(1'b1, 16'h0200 - 16'h00EC, 1'b0, 1'b0, 1'b0);  // refused entry 0x0114
        @(negedge clk);
        check(hi_overflow == 1'b1, 10, "hi_overflow set", {31'd0, hi_overflow}, 32'd1);
        expect_cur(10, 1'b1, 16'h0100);
        for (int k = 1; k <= DEPTH; k++) begin
            drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
            @(negedge clk);
            expect_cur(3, 1'b1, 16'(16'h0100 + 4 * k));  // R3 arrival order
        end
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        expect_cur(10, 1'b0, 16'h0000);  // R10 refused entry never dispatched
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check(hi_overflow == 1'b1 && lo_overflow == 1'b0 && hi_full == 1'b0, 10, "sticky flags",
              {29'd0, hi_overflow, lo_overflow, hi_full}, 32'd4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule